// File: doc/BRIEF.md
# Two-Speed Oscillator Start-up Controller

This block decides which oscillator drives the system clock while an external crystal comes up. From reset, and after any event that restarts the crystal, the system runs from the internal oscillator. Meanwhile a start-up timer in the external-clock domain counts crystal cycles. The timer's clear request and its completion travel between the two clock domains through two-flop synchronisers. When the count completes, the ready flag rises and the system clock is held low. The select moves to the external source only at a falling edge of the crystal clock that comes after the flag rose, so no short pulse reaches the clock tree.

The timer restarts on every event that may restart the crystal: the synchronous reset, a wake-from-sleep pulse, and a rising edge of the request for the primary clock. When fail-safe monitoring is enabled, a crystal that does not finish its start-up within a programmable number of internal-clock cycles is reported as failed. The select is then pinned to the internal oscillator until the next reset. A crystal-mode input of zero means the primary clock is the internal oscillator, and the start-up sequence is not run.

Top module: `twospd_clk_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first sample after it, `sel_code` is 2'b00 (internal), `osts` is 0 and `clk_fail` is 0.
- R2: After a restart event, `osts` rises only after at least OST_CYCLES (default 1024) rising edges of `ext_clk`, and no later than OST_CYCLES+16 such edges.
- R3: On the sample where `osts` first reads 1, `sel_code` is 2'b01 (clock held low). It changes to 2'b10 (external) only after a falling edge of `ext_clk` that occurs after `osts` was set.
- R4: With `xtal_mode` = 2'b00 (internal oscillator is primary), `sel_code` stays 2'b00 and `osts` stays 0, even while `ext_clk` runs.
- R5: A `wake_evt` pulse while the external clock is selected clears `osts` and returns `sel_code` to 2'b00 on the next cycle. A complete start-up count follows.
- R6: Dropping `prim_req` returns the block to the internal oscillator on the next cycle with `osts` at 0. Raising `prim_req` again starts a new full count.
- R7: A synchronous reset in the middle of a count discards it. The count measured from the release of reset is again at least OST_CYCLES.
- R8: With `fsafe_en` = 1 and no activity on `ext_clk`, `clk_fail` rises between FS_TIMEOUT and FS_TIMEOUT+4 internal cycles after reset release, with `sel_code` at 2'b00. It then ignores `wake_evt` and `prim_req` and clears only on reset.
- R9: With `fsafe_en` = 0 and `ext_clk` stopped, `clk_fail` never rises, and the block stays on the internal oscillator with `osts` at 0.
- R10: Every crystal mode `xtal_mode` = 2'b01, 2'b10 and 2'b11 runs the same sequence and ends with `sel_code` = 2'b10 and `osts` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Internal oscillator clock; control logic domain |
| ext_clk | input | 1 | External crystal clock being started |
| rst_n | input | 1 | Synchronous active-low reset (internal-clock domain) |
| wake_evt | input | 1 | One-cycle wake-from-sleep pulse; restarts the timer |
| fsafe_en | input | 1 | Enables the start-up failure timeout |
| prim_req | input | 1 | Request to run from the primary clock; a rising edge restarts the timer |
| xtal_mode | input | 2 | 00 internal primary, 01/10/11 crystal modes |
| sel_code | output | 2 | 00 internal, 01 held low, 10 external |
| osts | output | 1 | Start-up count complete, external clock in use |
| clk_fail | output | 1 | Sticky failure flag, cleared only by reset |

## Verification
A timer that is not cleared on a restart shows up at once. `osts` rises after far fewer than 1024 crystal edges from the restart, or stays high through a wake pulse, so the crystal-edge count taken at the rise is the telling number. A hand-over that skips the low phase, or that acts on a stale falling edge, puts 2'b10 on `sel_code` with no falling edge after the ready flag. This is visible within a few internal cycles. A timeout counter or sticky flag that is broken shows as a failure flag that rises at the wrong cycle, never rises, or drops on a wake pulse.

// File: rtl/osc_pkg.sv
// Package: shared state encoding and select codes of the start-up controller.
// Assumes: nothing; pure type and constant definitions.
package osc_pkg;

    // Control state of the internal-clock domain sequencer
    typedef enum logic [2:0] {
        ST_INT  = 3'd0,   // running internal, primary not active
        ST_CLR  = 3'd1,   // clearing the start-up timer (handshake)
        ST_CNT  = 3'd2,   // timer counting crystal cycles
        ST_HOLD = 3'd3,   // count done, system clock held low
        ST_EXT  = 3'd4,   // external clock selected
        ST_FAIL = 3'd5    // crystal failed to start, sticky
    } su_state_t;

    localparam logic [1:0] SEL_INT  = 2'b00;
    localparam logic [1:0] SEL_HOLD = 2'b01;
    localparam logic [1:0] SEL_EXT  = 2'b10;

    localparam logic [1:0] XM_NONE  = 2'b00;

endpackage

// File: rtl/bit_sync.sv
// Module: multi-stage flop synchroniser for a bundle of independent bits.
// Assumes: each bit is a slow level or toggle; bits are not related so no
// bus coherency is implied. Synchronous active-low reset to zero.
module bit_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Let metastability settle through the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ost_counter.sv
// Module: start-up timer in the external-clock domain. Counts OST_CYCLES
// rising edges of the crystal after the clear request drops, acknowledges a
// clear, and toggles a marker on every falling edge of the crystal.
// Assumes: clr_s is already synchronised to ext_clk; reset is synchronous to
// ext_clk and only takes effect while the crystal runs.
module ost_counter #(
    parameter int OST_CYCLES = 1024
) (
    input  logic ext_clk,
    input  logic ext_rst_n,
    input  logic clr_s,
    output logic cnt_done,
    output logic clr_ack,
    output logic fall_tgl
);
    localparam int CW = $clog2(OST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);
    localparam logic [CW-1:0] FULL = CW'(OST_CYCLES);

    logic [CW-1:0] cnt;

    // Count crystal edges; a clear request wins and is acknowledged
    always_ff @(posedge ext_clk) begin
        if (!ext_rst_n) begin
            cnt      <= '0;
            cnt_done <= 1'b0;
            clr_ack  <= 1'b0;
        end else if (clr_s) begin
            cnt      <= '0;
            cnt_done <= 1'b0;
            clr_ack  <= 1'b1;
        end else begin
            clr_ack <= 1'b0;
            if (!cnt_done) begin
                if (cnt == LAST) begin
                    cnt      <= FULL;
                    cnt_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Mark every falling crystal edge for the hand-over logic
    always_ff @(negedge ext_clk) begin
        if (!ext_rst_n) fall_tgl <= 1'b0;
        else            fall_tgl <= ~fall_tgl;
    end

    // R2: a clear request leaves the timer empty on the next edge
    a_r2_clear_empties: assert property (@(posedge ext_clk) disable iff (!ext_rst_n)
        clr_s |=> (cnt == '0 && !cnt_done));

    // R2: the timer never runs past its terminal count
    a_r2_no_overflow: assert property (@(posedge ext_clk) disable iff (!ext_rst_n)
        cnt <= FULL);

endmodule

// File: rtl/startup_fsm.sv
// Module: internal-clock domain sequencer. Decides restarts, runs the
// clear handshake with the crystal-domain timer, waits for completion,
// holds the clock low until a fresh falling crystal edge, and times out a
// crystal that never starts.
// Assumes: ack_s, done_s and fall_s come through synchronisers clocked by
// int_clk; rst_n is synchronous to int_clk.
module startup_fsm
    import osc_pkg::*;
#(
    parameter int FS_TIMEOUT = 4096
) (
    input  logic       int_clk,
    input  logic       rst_n,
    input  logic       wake_evt,
    input  logic       fsafe_en,
    input  logic       prim_req,
    input  logic [1:0] xtal_mode,
    input  logic       ack_s,
    input  logic       done_s,
    input  logic       fall_s,
    output logic       ost_clr,
    output logic [1:0] sel_code,
    output logic       osts,
    output logic       clk_fail
);
    localparam int TW = $clog2(FS_TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(FS_TIMEOUT - 1);
    localparam logic [TW-1:0] T_MAX  = TW'(FS_TIMEOUT);
    localparam logic [1:0]    SETTLE = 2'd2;

    su_state_t     state, nxt;
    logic          prim_d;
    logic          fall_d;
    logic [TW-1:0] timer;
    logic [1:0]    hold_age;

    logic active, restart, fall_seen, timed, tmo, enter_clr;

    // Decode the events that restart or abort the sequence
    always_comb begin
        active    = prim_req && (xtal_mode != XM_NONE);
        restart   = wake_evt || (prim_req && !prim_d);
        fall_seen = fall_s ^ fall_d;
        timed     = (state == ST_CLR) || (state == ST_CNT) || (state == ST_HOLD);
        tmo       = fsafe_en && timed && (timer == T_LAST);
    end

    // Next-state choice, highest priority first
    always_comb begin
        nxt = state;
        if (state == ST_FAIL) begin
            nxt = ST_FAIL;
        end else if (!active) begin
            nxt = ST_INT;
        end else if (tmo) begin
            nxt = ST_FAIL;
        end else if (restart) begin
            nxt = ST_CLR;
        end else begin
            case (state)
                ST_INT:  nxt = ST_CLR;
                ST_CLR:  if (ack_s && !done_s) nxt = ST_CNT;
                ST_CNT:  if (done_s) nxt = ST_HOLD;
                ST_HOLD: if (hold_age == SETTLE && fall_seen) nxt = ST_EXT;
                default: nxt = state;
            endcase
        end
        enter_clr = (nxt == ST_CLR) && ((state != ST_CLR) || restart);
    end

    // State, edge history and settle counter
    always_ff @(posedge int_clk) begin
        if (!rst_n) begin
            state    <= ST_INT;
            prim_d   <= 1'b0;
            fall_d   <= 1'b0;
            hold_age <= '0;
        end else begin
            state  <= nxt;
            prim_d <= prim_req;
            fall_d <= fall_s;
            if (state != ST_HOLD)      hold_age <= '0;
            else if (hold_age != SETTLE) hold_age <= hold_age + 1'b1;
        end
    end

    // Fail-safe timer: cleared on each restart, runs during start-up
    always_ff @(posedge int_clk) begin
        if (!rst_n)                   timer <= '0;
        else if (enter_clr || !timed) timer <= '0;
        else if (timer != T_MAX)      timer <= timer + 1'b1;
    end

    // Output decode
    always_comb begin
        ost_clr  = (state == ST_INT) || (state == ST_CLR) || (state == ST_FAIL);
        osts     = (state == ST_HOLD) || (state == ST_EXT);
        clk_fail = (state == ST_FAIL);
        case (state)
            ST_HOLD: sel_code = SEL_HOLD;
            ST_EXT:  sel_code = SEL_EXT;
            default: sel_code = SEL_INT;
        endcase
    end

    // R2: the ready flag only rises once the synchronised count is done
    a_r2_osts_after_done: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(osts) |-> done_s);

    // R3: the external select is always preceded by the held-low phase
    a_r3_ext_via_hold: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(sel_code == SEL_EXT) |-> $past(sel_code == SEL_HOLD));

    // R4: internal primary mode never leaves the internal oscillator
    a_r4_no_crystal_no_switch: assert property (@(posedge int_clk) disable iff (!rst_n)
        (xtal_mode == XM_NONE) |=> (sel_code == SEL_INT && !osts));

    // R5: a wake pulse always drops the ready flag
    a_r5_wake_restarts: assert property (@(posedge int_clk) disable iff (!rst_n)
        (wake_evt && !clk_fail) |=> !osts);

    // R8: the failure flag holds until reset
    a_r8_fail_sticky: assert property (@(posedge int_clk) disable iff (!rst_n)
        clk_fail |=> clk_fail);

    // R9: a failure only appears with fail-safe enabled
    a_r9_fail_needs_enable: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(clk_fail) |-> $past(fsafe_en));

endmodule

// File: rtl/twospd_clk_ctrl.sv
// Module: two-speed start-up clock controller top. Ties the crystal-domain
// start-up timer to the internal-domain sequencer through synchronisers.
// Assumes: int_clk runs from power-up; ext_clk may be absent; rst_n is
// synchronous to int_clk and is re-timed here for the crystal domain.
module twospd_clk_ctrl #(
    parameter int OST_CYCLES = 1024,
    parameter int FS_TIMEOUT = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic       int_clk,
    input  logic       ext_clk,
    input  logic       rst_n,
    input  logic       wake_evt,
    input  logic       fsafe_en,
    input  logic       prim_req,
    input  logic [1:0] xtal_mode,
    output logic [1:0] sel_code,
    output logic       osts,
    output logic       clk_fail
);
    localparam int BACK_W = 3;

    logic              ext_rst_n;
    logic              ost_clr, clr_s;
    logic              cnt_done, clr_ack, fall_tgl;
    logic [BACK_W-1:0] back_s;

    // Reset re-timed into the crystal domain
    bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(ext_clk), .rst_n(1'b1), .d(rst_n), .q(ext_rst_n));

    // Clear request into the crystal domain
    bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_clr_sync (
        .clk(ext_clk), .rst_n(ext_rst_n), .d(ost_clr), .q(clr_s));

    ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .ext_clk(ext_clk), .ext_rst_n(ext_rst_n), .clr_s(clr_s),
        .cnt_done(cnt_done), .clr_ack(clr_ack), .fall_tgl(fall_tgl));

    // Acknowledge, completion and falling-edge marker back to internal domain
    bit_sync #(.WIDTH(BACK_W), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk(int_clk), .rst_n(rst_n),
        .d({fall_tgl, cnt_done, clr_ack}), .q(back_s));

    startup_fsm #(.FS_TIMEOUT(FS_TIMEOUT)) u_fsm (
        .int_clk(int_clk), .rst_n(rst_n), .wake_evt(wake_evt),
        .fsafe_en(fsafe_en), .prim_req(prim_req), .xtal_mode(xtal_mode),
        .ack_s(back_s[0]), .done_s(back_s[1]), .fall_s(back_s[2]),
        .ost_clr(ost_clr), .sel_code(sel_code), .osts(osts),
        .clk_fail(clk_fail));

endmodule

// File: tb/twospd_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module twospd_clk_ctrl_tb_top;
    localparam int OSTC = 1024;
    localparam int FST  = 4096;

    logic       int_clk = 1'b0, ext_clk = 1'b0, ext_run = 1'b1;
    logic       rst_n = 1'b0, wake_evt = 1'b0, fsafe_en = 1'b0, prim_req = 1'b0;
    logic [1:0] xtal_mode = 2'b00;
    logic [1:0] sel_code;
    logic       osts, clk_fail;

    int checks = 0, fails = 0;
    int ext_pos = 0, ext_neg = 0;

    twospd_clk_ctrl dut_i (
        .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
        .wake_evt(wake_evt), .fsafe_en(fsafe_en), .prim_req(prim_req),
        .xtal_mode(xtal_mode), .sel_code(sel_code), .osts(osts),
        .clk_fail(clk_fail));

    always #5 int_clk = ~int_clk;
    always begin
        #12.5;
        if (ext_run) ext_clk = ~ext_clk;
    end
    always @(posedge ext_clk) ext_pos++;
    always @(negedge ext_clk) ext_neg++;

    // fields: mode[1:0], fsafe, ext running, expected osts, expected fail
    localparam logic [5:0] VEC [0:5] = '{
        6'b01_1_1_1_0,   // R10 LP-style crystal
        6'b10_0_1_1_0,   // R10 second crystal mode, fail-safe off
        6'b11_1_1_1_0,   // R10 third crystal mode
        6'b00_1_1_0_0,   // R4 internal primary
        6'b11_1_0_0_1,   // R8 dead crystal with fail-safe
        6'b01_0_0_0_0    // R9 dead crystal without fail-safe
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge int_clk);
    endtask

    task automatic do_reset();
        @(negedge int_clk);
        rst_n = 1'b0;
        cyc(10);
        rst_n = 1'b1;
    endtask

    // Wait for the ready flag; return crystal rising edges since call
    task automatic wait_osts(output int edges, output bit seen, output int neg_before);
        int start = ext_pos;
        int prev_neg = ext_neg;
        seen = 1'b0;
        neg_before = prev_neg;
        for (int i = 0; i < 8000; i++) begin
            @(negedge int_clk);
            if (osts) begin
                seen = 1'b1;
                neg_before = prev_neg;
                break;
            end
            prev_neg = ext_neg;
        end
        edges = ext_pos - start;
    endtask

    task automatic startup_run(input string req);
        int  edges, nb;
        bit  seen;
        wait_osts(edges, seen, nb);
        chk(seen, req, int'(seen), 1);
        chk(edges >= OSTC && edges <= OSTC + 16, req, edges, OSTC);
        chk(sel_code == 2'b01, "R3 held low at ready", int'(sel_code), 1);
        for (int i = 0; i < 200; i++) begin
            if (sel_code == 2'b10) break;
            @(negedge int_clk);
        end
        chk(sel_code == 2'b10, "R3 external selected", int'(sel_code), 2);
        chk(ext_neg > nb, "R3 fresh falling edge", ext_neg - nb, 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int  edges, nb, n;
        bit  seen;

        // R1 reset state
        prim_req = 1'b1; xtal_mode = 2'b01; fsafe_en = 1'b1;
        cyc(5);
        chk(sel_code == 2'b00, "R1 select in reset", int'(sel_code), 0);
        chk(!osts, "R1 ready in reset", int'(osts), 0);
        chk(!clk_fail, "R1 fail in reset", int'(clk_fail), 0);
        rst_n = 1'b1;
        @(negedge int_clk);
        chk(sel_code == 2'b00 && !osts && !clk_fail, "R1 after release",
            int'({sel_code, osts, clk_fail}), 0);

        // Vector table
        for (int v = 0; v < 6; v++) begin
            xtal_mode = VEC[v][5:4];
            fsafe_en  = VEC[v][3];
            ext_run   = VEC[v][2];
            prim_req  = 1'b1;
            do_reset();
            cyc(6000);
            chk(osts == VEC[v][1], $sformatf("R10/R4/R8/R9 vec%0d osts", v),
                int'(osts), int'(VEC[v][1]));
            chk(sel_code == (VEC[v][1] ? 2'b10 : 2'b00),
                $sformatf("R10/R4 vec%0d select", v), int'(sel_code),
                VEC[v][1] ? 2 : 0);
            chk(clk_fail == VEC[v][0], $sformatf("R8/R9 vec%0d fail", v),
                int'(clk_fail), int'(VEC[v][0]));
        end

        // R2/R3 timing from reset
        ext_run = 1'b1; xtal_mode = 2'b10; fsafe_en = 1'b1; prim_req = 1'b1;
        do_reset();
        startup_run("R2 count after reset");

        // R5 wake while external
        wake_evt = 1'b1;
        @(negedge int_clk);
        wake_evt = 1'b0;
        chk(!osts && sel_code == 2'b00, "R5 wake clears", int'({sel_code, osts}), 0);
        startup_run("R5 recount after wake");

        // R6 primary request drop and rise
        prim_req = 1'b0;
        @(negedge int_clk);
        chk(!osts && sel_code == 2'b00, "R6 request dropped", int'({sel_code, osts}), 0);
        cyc(50);
        prim_req = 1'b1;
        startup_run("R6 recount after request");

        // R7 reset in mid-count
        do_reset();
        for (int i = 0; i < 400; i++) @(negedge ext_clk);
        chk(!osts, "R7 still counting", int'(osts), 0);
        do_reset();
        startup_run("R7 recount after reset");

        // R8 timeout cycle, stickiness and reset release
        ext_run = 1'b0; fsafe_en = 1'b1; prim_req = 1'b1; xtal_mode = 2'b01;
        do_reset();
        n = 0;
        while (!clk_fail && n < 6000) begin
            @(negedge int_clk);
            n++;
        end
        chk(n >= FST && n <= FST + 4, "R8 timeout cycle", n, FST);
        chk(sel_code == 2'b00, "R8 internal on fail", int'(sel_code), 0);
        wake_evt = 1'b1;
        @(negedge int_clk);
        wake_evt = 1'b0;
        prim_req = 1'b0;
        cyc(3);
        prim_req = 1'b1;
        cyc(3);
        chk(clk_fail && sel_code == 2'b00, "R8 sticky", int'(clk_fail), 1);
        ext_run = 1'b1;
        do_reset();
        @(negedge int_clk);
        chk(!clk_fail, "R8 reset clears", int'(clk_fail), 0);
        wait_osts(edges, seen, nb);
        chk(seen, "R8 restart after clear", int'(seen), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule